// File: doc/BRIEF.md
# Fall-Through FIFO with Strobe and Ready-Flag Handshake

This block is a clocked model of a 64-entry, 9-bit first-in first-out buffer in which every word moves to the read end without a read request. The writer drives a level strobe `shift_in`. Raising it captures `wr_data` into an entry register and drops the write-ready flag. Lowering it lets the word travel into storage, which takes a set number of cycles. The reader works the same way with `shift_out` and the read-ready flag. Raising the strobe takes the word in the presentation register and drops the flag. Lowering it lets the next stored word come forward after the same latency. Both strobes pass through two-flop synchronizers, so they may come from another clock domain.

The writer side is a five-state machine. `W_READY` drives the flag high. A strobe that is high and not yet used moves it to `W_HOLD`, which waits for the strobe to fall. It then goes to `W_RIPPLE`, which counts the latency. From there it goes to `W_READY`, or to `W_FULL` when no room remains. `W_FULL` moves to `W_BUBBLE` as soon as a read frees a slot, and `W_BUBBLE` counts the latency before returning to `W_READY`. The reader side has four states. `R_EMPTY` moves to `R_FILL` when storage holds a word. `R_FILL` counts the latency and then loads the presentation register. `R_VALID` drives the flag high and moves to `R_BUSY` on an unused high strobe. `R_BUSY` waits for the strobe to fall and then goes to `R_FILL` or to `R_EMPTY`. A strobe that is already high when a state machine enters its ready state is acted on at once. This is how a write waiting on a full buffer, or a read waiting on an empty one, completes as a single transfer.

The active-low master reset is asynchronous. It clears both state machines and discards the stored words, but the presentation register keeps its value. The active-low output enable only gates a data-valid qualifier.

Top module: `fall_thru_fifo`

## Requirements
- R1: The buffer holds 64 nine-bit words, counting the word in the presentation register, and returns them in the order they were written.
- R2: While `mr_n` is low, `in_rdy` is 1 and `out_rdy` is 0 and `rd_data` keeps its value. After release no word from before the reset is ever presented.
- R3: With `in_rdy` high, a high `shift_in` captures `wr_data`, and `in_rdy` falls and stays low for as long as the strobe stays high.
- R4: After `shift_in` falls, `in_rdy` stays low for at least LAT cycles. It then rises if room remains and stays low if the buffer is now full.
- R5: With `out_rdy` high, a high `shift_out` makes `out_rdy` fall. After the strobe falls, the next word appears at `rd_data` no sooner than LAT cycles later, together with `out_rdy` high.
- R6: While `out_rdy` is high, `rd_data` does not change. Once the last word has been taken, `out_rdy` stays low and `rd_data` keeps showing that word.
- R7: If `shift_in` is held high while the buffer is full, a read makes `in_rdy` pulse high. The waiting word is then captured and `in_rdy` returns low.
- R8: If `shift_out` is held high while the buffer is empty, a later write makes `out_rdy` pulse high. That word is taken automatically, and `out_rdy` stays low until the strobe is lowered.
- R9: A write strobe that rises and falls while the buffer is full stores nothing. A read strobe on an empty buffer changes neither `rd_data` nor `out_rdy`.
- R10: If `shift_in` is high while `mr_n` is low, the word on `wr_data` is captured after reset is released.
- R11: `rd_valid` is 1 exactly when `oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mr_n | input | 1 | Asynchronous master reset, active low |
| shift_in | input | 1 | Write strobe, level sampled |
| shift_out | input | 1 | Read strobe, level sampled |
| oe_n | input | 1 | Output enable, active low |
| wr_data | input | 9 | Word to be written |
| rd_data | output | 9 | Word in the presentation register |
| rd_valid | output | 1 | Data qualifier driven from the output enable |
| in_rdy | output | 1 | Write-ready flag |
| out_rdy | output | 1 | Read-ready flag |

## Verification
On every cycle, the assertions check four things. A ready flag falls only after its strobe was high. The write flag rises only when room exists. Storage is never pushed past its depth or popped while empty. The presented word holds still while the read flag stays high. Only the directed scenarios can show the rest: the end-to-end word order, the 64-word limit, the single flag pulses when a strobe is held through a full or empty condition, the capture of a strobe held across reset, and the duration of the busy windows.

// File: rtl/ftf_pkg.sv
package ftf_pkg;
    typedef enum logic [2:0] {
        W_READY,
        W_HOLD,
        W_RIPPLE,
        W_FULL,
        W_BUBBLE
    } wr_state_t;

    typedef enum logic [1:0] {
        R_EMPTY,
        R_FILL,
        R_VALID,
        R_BUSY
    } rd_state_t;
endpackage

// File: rtl/ftf_sync.sv
module ftf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ftf_ring.sv
module ftf_ring #(
    parameter int W     = 9,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               pop_data,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign pop_data = mem[rptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));  // R1
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));  // R9
endmodule

// File: rtl/ftf_wr.sv
module ftf_wr
    import ftf_pkg::*;
#(
    parameter int W     = 9,
    parameter int DEPTH = 64,
    parameter int LAT   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       si_lvl,
    input  logic [W-1:0]               din,
    input  logic [$clog2(DEPTH+1)-1:0] total,
    output logic                       push,
    output logic [W-1:0]               push_data,
    output logic                       dir
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int LW = $clog2(LAT + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [LW-1:0] LAT_CNT  = LW'(LAT);

    wr_state_t     state, state_nxt;
    logic [LW-1:0] cnt, cnt_nxt;
    logic          si_used, capture;
    logic [W-1:0]  in_word;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        capture   = 1'b0;
        push      = 1'b0;
        unique case (state)
            W_READY: begin
                if (si_lvl && !si_used) begin
                    capture   = 1'b1;
                    state_nxt = W_HOLD;
                end
            end
            W_HOLD: begin
                if (!si_lvl) begin
                    state_nxt = W_RIPPLE;
                    cnt_nxt   = LAT_CNT;
                end
            end
            W_RIPPLE: begin
                if (cnt <= LW'(1)) begin
                    push      = 1'b1;
                    state_nxt = (total >= FULL_CNT - 1'b1) ? W_FULL : W_READY;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            W_FULL: begin
                if (total < FULL_CNT) begin
                    state_nxt = W_BUBBLE;
                    cnt_nxt   = LAT_CNT;
                end
            end
            W_BUBBLE: begin
                if (cnt <= LW'(1)) state_nxt = W_READY;
                else               cnt_nxt   = cnt - 1'b1;
            end
            default: state_nxt = W_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= W_READY;
            cnt     <= '0;
            si_used <= 1'b0;
            in_word <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            if (!si_lvl)      si_used <= 1'b0;
            else if (capture) si_used <= 1'b1;
            if (capture) in_word <= din;
        end
    end

    always_comb begin
        dir       = (state == W_READY);
        push_data = in_word;
    end

    AST_DIR_FALL_NEEDS_SI: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dir) |-> $past(si_lvl));  // R3
    AST_DIR_RISE_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir) |-> (total < FULL_CNT));  // R4
endmodule

// File: rtl/ftf_rd.sv
module ftf_rd
    import ftf_pkg::*;
#(
    parameter int W     = 9,
    parameter int DEPTH = 64,
    parameter int LAT   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       so_lvl,
    input  logic [$clog2(DEPTH+1)-1:0] ring_cnt,
    input  logic [W-1:0]               pop_data,
    output logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       dor,
    output logic                       ostage_full
);
    localparam int LW = $clog2(LAT + 1);
    localparam logic [LW-1:0] LAT_CNT = LW'(LAT);

    rd_state_t     state, state_nxt;
    logic [LW-1:0] cnt, cnt_nxt;
    logic          so_used, release_w;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        pop       = 1'b0;
        release_w = 1'b0;
        unique case (state)
            R_EMPTY: begin
                if (ring_cnt != '0) begin
                    state_nxt = R_FILL;
                    cnt_nxt   = LAT_CNT;
                end
            end
            R_FILL: begin
                if (cnt <= LW'(1)) begin
                    pop       = 1'b1;
                    state_nxt = R_VALID;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            R_VALID: begin
                if (so_lvl && !so_used) begin
                    release_w = 1'b1;
                    state_nxt = R_BUSY;
                end
            end
            R_BUSY: begin
                if (!so_lvl) begin
                    if (ring_cnt != '0) begin
                        state_nxt = R_FILL;
                        cnt_nxt   = LAT_CNT;
                    end else begin
                        state_nxt = R_EMPTY;
                    end
                end
            end
            default: state_nxt = R_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= R_EMPTY;
            cnt     <= '0;
            so_used <= 1'b0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            if (!so_lvl)        so_used <= 1'b0;
            else if (release_w) so_used <= 1'b1;
        end
    end

    // Presentation register: not cleared by master reset
    always_ff @(posedge clk) begin
        if (pop) dout <= pop_data;
    end

    always_comb begin
        dor         = (state == R_VALID);
        ostage_full = (state == R_VALID);
    end

    AST_DOR_FALL_NEEDS_SO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dor) |-> $past(so_lvl));  // R5
endmodule

// File: rtl/fall_thru_fifo.sv
module fall_thru_fifo #(
    parameter int W          = 9,
    parameter int DEPTH      = 64,
    parameter int LAT        = 2,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         mr_n,
    input  logic         shift_in,
    input  logic         shift_out,
    input  logic         oe_n,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         in_rdy,
    output logic         out_rdy
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          si_lvl, so_lvl;
    logic          push, pop, ostage_full;
    logic [W-1:0]  push_data, pop_data;
    logic [CW-1:0] ring_cnt, total;

    ftf_sync #(.STAGES(SYNC_DEPTH)) u_si_sync (
        .clk(clk), .rst_n(mr_n), .d(shift_in), .q(si_lvl)
    );
    ftf_sync #(.STAGES(SYNC_DEPTH)) u_so_sync (
        .clk(clk), .rst_n(mr_n), .d(shift_out), .q(so_lvl)
    );

    ftf_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(mr_n),
        .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pop_data),
        .count(ring_cnt)
    );

    assign total = ring_cnt + CW'(ostage_full);

    ftf_wr #(.W(W), .DEPTH(DEPTH), .LAT(LAT)) u_wr (
        .clk(clk), .rst_n(mr_n), .si_lvl(si_lvl), .din(wr_data),
        .total(total), .push(push), .push_data(push_data), .dir(in_rdy)
    );

    ftf_rd #(.W(W), .DEPTH(DEPTH), .LAT(LAT)) u_rd (
        .clk(clk), .rst_n(mr_n), .so_lvl(so_lvl), .ring_cnt(ring_cnt),
        .pop_data(pop_data), .pop(pop), .dout(rd_data), .dor(out_rdy),
        .ostage_full(ostage_full)
    );

    assign rd_valid = !oe_n;

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!mr_n)
        (out_rdy && $past(out_rdy)) |-> $stable(rd_data));  // R6
endmodule

// File: tb/test_fall_thru_fifo.sv
module test_fall_thru_fifo;
    localparam int W = 9;
    localparam int DEPTH = 64;
    localparam int LAT = 2;

    logic         clk = 1'b0;
    logic         mr_n, shift_in, shift_out, oe_n;
    logic [W-1:0] wr_data;
    logic [W-1:0] rd_data;
    logic         rd_valid, in_rdy, out_rdy;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fall_thru_fifo #(.W(W), .DEPTH(DEPTH), .LAT(LAT)) i_fall_thru_fifo (
        .clk(clk), .mr_n(mr_n), .shift_in(shift_in), .shift_out(shift_out),
        .oe_n(oe_n), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .in_rdy(in_rdy), .out_rdy(out_rdy)
    );

    function automatic logic [W-1:0] pat(input int i);
        return W'((i * 37 + 5) & 'h1FF);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_dir(input logic v, input int lim, output bit ok);
        ok = 0;
        for (int k = 0; k < lim; k++) begin
            if (in_rdy === v) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic wait_dor(input logic v, input int lim, output bit ok);
        ok = 0;
        for (int k = 0; k < lim; k++) begin
            if (out_rdy === v) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic write_word(input logic [W-1:0] w, input string req);
        bit ok;
        wait_dir(1'b1, 200, ok);
        if (!ok) check(0, req, in_rdy, 1);
        wr_data  = w;
        shift_in = 1'b1;
        wait_dir(1'b0, 20, ok);
        if (!ok) check(0, req, in_rdy, 0);
        tick(1);
        shift_in = 1'b0;
    endtask

    task automatic read_word(output logic [W-1:0] w, input string req);
        bit ok;
        wait_dor(1'b1, 200, ok);
        if (!ok) check(0, req, out_rdy, 1);
        w = rd_data;
        shift_out = 1'b1;
        wait_dor(1'b0, 20, ok);
        if (!ok) check(0, req, out_rdy, 0);
        shift_out = 1'b0;
        tick(3);
    endtask

    task automatic do_reset();
        mr_n = 1'b0;
        tick(2);
        mr_n = 1'b1;
        tick(2);
    endtask

    task automatic t_reset_state();
        mr_n = 1'b0;
        tick(2);
        check(in_rdy === 1'b1, "R2", in_rdy, 1);
        check(out_rdy === 1'b0, "R2", out_rdy, 0);
        mr_n = 1'b1;
        tick(2);
    endtask

    task automatic t_oe();
        oe_n = 1'b1;
        tick(1);
        check(rd_valid === 1'b0, "R11", rd_valid, 0);
        oe_n = 1'b0;
        tick(1);
        check(rd_valid === 1'b1, "R11", rd_valid, 1);
    endtask

    task automatic t_busy_windows();
        int cyc;
        bit ok;
        logic [W-1:0] w = 9'h0C3;
        wr_data  = w;
        shift_in = 1'b1;
        tick(6);
        check(in_rdy === 1'b0, "R3", in_rdy, 0);
        shift_in = 1'b0;
        cyc = 0;
        while (in_rdy !== 1'b1 && cyc < 50) begin tick(1); cyc++; end
        check(cyc >= LAT && cyc < 50, "R4", cyc, LAT);
        wait_dor(1'b1, 100, ok);
        check(ok && rd_data === w, "R5", rd_data, w);
        shift_out = 1'b1;
        tick(6);
        check(out_rdy === 1'b0, "R5", out_rdy, 0);
        shift_out = 1'b0;
        tick(LAT + 10);
        check(out_rdy === 1'b0, "R6", out_rdy, 0);
        check(rd_data === w, "R6", rd_data, w);
    endtask

    task automatic t_fill_drain();
        logic [W-1:0] got;
        int bad = 0;
        for (int i = 0; i < DEPTH; i++) write_word(pat(i), "R1");
        tick(LAT + 10);
        check(in_rdy === 1'b0, "R4", in_rdy, 0);
        wr_data  = 9'h1FF;
        shift_in = 1'b1;
        tick(5);
        shift_in = 1'b0;
        tick(LAT + 10);
        check(in_rdy === 1'b0, "R9", in_rdy, 0);
        for (int i = 0; i < DEPTH; i++) begin
            read_word(got, "R1");
            if (got !== pat(i)) begin
                bad++;
                check(0, "R1", got, pat(i));
            end
        end
        check(bad == 0, "R1", bad, 0);
        tick(LAT + 10);
        check(out_rdy === 1'b0, "R9", out_rdy, 0);
        check(rd_data === pat(DEPTH - 1), "R6", rd_data, pat(DEPTH - 1));
        shift_out = 1'b1;
        tick(5);
        shift_out = 1'b0;
        tick(LAT + 10);
        check(out_rdy === 1'b0, "R9", out_rdy, 0);
        check(rd_data === pat(DEPTH - 1), "R9", rd_data, pat(DEPTH - 1));
    endtask

    task automatic t_held_si_full();
        logic [W-1:0] got;
        bit rose = 0, fell = 0;
        for (int i = 0; i < DEPTH; i++) write_word(pat(i + 100), "R7");
        tick(LAT + 10);
        wr_data  = 9'h1AA;
        shift_in = 1'b1;
        tick(5);
        check(in_rdy === 1'b0, "R7", in_rdy, 0);
        read_word(got, "R7");
        check(got === pat(100), "R7", got, pat(100));
        for (int k = 0; k < 100; k++) begin
            if (in_rdy === 1'b1) rose = 1;
            if (rose && in_rdy === 1'b0) begin fell = 1; break; end
            tick(1);
        end
        check(rose && fell, "R7", {rose, fell}, 3);
        shift_in = 1'b0;
        tick(LAT + 10);
        check(in_rdy === 1'b0, "R7", in_rdy, 0);
        for (int i = 1; i < DEPTH; i++) read_word(got, "R7");
        read_word(got, "R7");
        check(got === 9'h1AA, "R7", got, 9'h1AA);
    endtask

    task automatic t_held_so_empty();
        bit seen = 0;
        logic [W-1:0] got = '0;
        shift_out = 1'b1;
        tick(5);
        write_word(9'h055, "R8");
        for (int k = 0; k < 100; k++) begin
            if (out_rdy === 1'b1) begin seen = 1; got = rd_data; break; end
            tick(1);
        end
        check(seen && got === 9'h055, "R8", got, 9'h055);
        tick(LAT + 10);
        check(out_rdy === 1'b0, "R8", out_rdy, 0);
        shift_out = 1'b0;
        tick(LAT + 10);
        check(out_rdy === 1'b0, "R8", out_rdy, 0);
    endtask

    task automatic t_reset_midway();
        logic [W-1:0] got;
        for (int i = 0; i < 3; i++) write_word(pat(i + 200), "R2");
        read_word(got, "R2");
        mr_n = 1'b0;
        tick(2);
        check(in_rdy === 1'b1 && out_rdy === 1'b0, "R2", {in_rdy, out_rdy}, 2);
        check(rd_data === pat(200), "R2", rd_data, pat(200));
        mr_n = 1'b1;
        tick(LAT + 20);
        check(out_rdy === 1'b0, "R2", out_rdy, 0);
    endtask

    task automatic t_si_during_reset();
        logic [W-1:0] got;
        bit ok;
        mr_n     = 1'b0;
        wr_data  = 9'h123;
        shift_in = 1'b1;
        tick(3);
        mr_n = 1'b1;
        wait_dir(1'b0, 20, ok);
        check(ok, "R10", in_rdy, 0);
        wr_data = 9'h000;
        tick(1);
        shift_in = 1'b0;
        read_word(got, "R10");
        check(got === 9'h123, "R10", got, 9'h123);
    endtask

    initial begin
        mr_n = 1'b0; shift_in = 1'b0; shift_out = 1'b0; oe_n = 1'b0; wr_data = '0;
        tick(3);
        t_reset_state();
        t_oe();
        t_busy_windows();
        do_reset();
        t_fill_drain();
        do_reset();
        t_held_si_full();
        do_reset();
        t_held_so_empty();
        do_reset();
        t_reset_midway();
        t_si_during_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule